// File: doc/BRIEF.md
# Split-Byte Address Stepper

This block produces the instruction address and the data effective address for the front end of a processor whose address path is eight bits wide. Each 16-bit address is held as two separate byte registers. One narrow adder updates the low byte in the cycle that a command is accepted. The high byte is not part of that add. When the low-byte add carries out, or borrows on a backward branch, the high byte is corrected in the following cycle, and `busy_o` marks that extra cycle.

A sequencer drives one command per cycle through `cmd_valid_i` and `cmd_op_i`. The available commands are: step the instruction address, add a signed branch displacement, load a jump target, form a page-zero indexed address, and form an indexed address from a fetched 16-bit base. While `busy_o` is high the addresses are not final and no new command is taken. A command that the sequencer holds across that cycle is therefore lost, so the sequencer waits for `busy_o` to fall.

Top module: `pc_split_unit`

## Requirements
- R1: While `rst_ni` is low and after it is released, `pc_o` equals the parameter `RESET_VEC`, `ea_o` is 0 and `busy_o` is 0.
- R2: Command code 1 (step) adds one to the low byte of `pc_o`. If the low byte does not wrap, `pc_o` holds the new value one cycle after acceptance and `busy_o` stays low.
- R3: When a step starts from low byte 0xFF, `busy_o` is high for exactly one cycle. During that cycle `pc_o` shows low byte 0x00 with the old high byte. After it, the high byte has gone up by one, modulo 2^16.
- R4: Command code 2 (branch) adds `offset_i` as a signed 8-bit value to `pc_o`. A carry out of the low byte raises the high byte and a borrow lowers it, and each costs one `busy_o` cycle. A branch that stays in its page costs none.
- R5: Command code 3 (jump) loads `pc_o` with `base_i` in one cycle and never raises `busy_o`.
- R6: Command code 4 (page-zero indexed) sets `ea_o` to {0x00, (base_i[7:0] + index_i) mod 256}. It ignores `base_i[15:8]` and never raises `busy_o`.
- R7: Command code 5 (indexed from base) sets `ea_o` to `base_i + index_i`. It costs one `busy_o` cycle exactly when the low-byte sum exceeds 0xFF.
- R8: A command that is presented while `busy_o` is high is dropped and changes neither `pc_o` nor `ea_o`.
- R9: Code 0 and codes 6 and 7 are idle and leave both addresses unchanged. With `cmd_valid_i` low, both addresses are also unchanged.
- R10: Page crossings from a step and from a following indexed-from-base command add one cycle each, two extra cycles in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | A command is presented this cycle |
| cmd_op_i | input | 3 | Command code |
| base_i | input | 16 | Jump target, or base for indexed modes |
| offset_i | input | 8 | Signed branch displacement |
| index_i | input | 8 | Unsigned index value |
| pc_o | output | 16 | Instruction address |
| ea_o | output | 16 | Effective data address |
| busy_o | output | 1 | High-byte correction cycle in progress |

## Verification
The bench builds the block with an 8-bit byte width and a reset vector of 0x01FF. With that vector, the first step after reset already crosses a page, so the reset value and the carry path are checked together. The stimulus covers the low byte at 0xFF and 0x00, the extreme branch displacements +127 and -128, and wrap-around at the top and bottom of the 64K space. Commands are also issued during a correction cycle, and a step crossing is stacked with an indexed crossing.

// File: rtl/pc_split_pkg.sv
package pc_split_pkg;
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_STEP   = 3'd1,
    OP_BRANCH = 3'd2,
    OP_JUMP   = 3'd3,
    OP_ZPX    = 3'd4,
    OP_INDY   = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    FIX_NONE = 2'd0,
    FIX_INC  = 2'd1,
    FIX_DEC  = 2'd2
  } fix_e;
endpackage

// File: rtl/lo_byte_adder.sv
module lo_byte_adder #(
  parameter int W = 8
) (
  input  logic                  [W-1:0] a_i,
  input  logic                  [W-1:0] b_i,
  input  logic                          signed_i,
  output logic                  [W-1:0] sum_o,
  output pc_split_pkg::fix_e            fix_o
);
  import pc_split_pkg::*;

  logic [W:0] raw;

  assign raw   = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o = raw[W-1:0];

  // signed operand: negative without carry means borrow out of the byte
  always_comb begin
    fix_o = FIX_NONE;
    if (signed_i && b_i[W-1]) begin
      if (!raw[W]) fix_o = FIX_DEC;
    end else if (raw[W]) begin
      fix_o = FIX_INC;
    end
  end
endmodule

// File: rtl/hi_byte_stepper.sv
module hi_byte_stepper #(
  parameter int W = 8
) (
  input  logic [W-1:0] hi_i,
  input  logic         dec_i,
  output logic [W-1:0] hi_o
);
  assign hi_o = dec_i ? hi_i - 1'b1 : hi_i + 1'b1;
endmodule

// File: rtl/byte_pair_reg.sv
module byte_pair_reg #(
  parameter int          W      = 8,
  parameter logic [2*W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lo_we_i,
  input  logic [W-1:0] lo_d_i,
  input  logic         hi_we_i,
  input  logic [W-1:0] hi_d_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lo_o <= RST_VAL[W-1:0];
    else if (lo_we_i) lo_o <= lo_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_o <= RST_VAL[2*W-1:W];
    else if (hi_we_i) hi_o <= hi_d_i;
  end
endmodule

// File: rtl/pc_split_unit.sv
module pc_split_unit #(
  parameter int              W         = 8,
  parameter logic [2*W-1:0]  RESET_VEC = 16'hFFFC
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  input  logic [2:0]     cmd_op_i,
  input  logic [2*W-1:0] base_i,
  input  logic [W-1:0]   offset_i,
  input  logic [W-1:0]   index_i,
  output logic [2*W-1:0] pc_o,
  output logic [2*W-1:0] ea_o,
  output logic           busy_o
);
  import pc_split_pkg::*;

  localparam int NREG = 2;   // 0: instruction address, 1: effective address
  localparam int SEL_PC = 0;
  localparam int SEL_EA = 1;

  op_e  op;
  logic accept;
  logic busy_q, fix_dec_q, fix_ea_q;

  logic [W-1:0] add_a, add_b, add_sum;
  logic         add_signed;
  fix_e         add_fix;

  logic [W-1:0] lo_q [NREG];
  logic [W-1:0] hi_q [NREG];
  logic         lo_we [NREG];
  logic         hi_we [NREG];
  logic [W-1:0] lo_d [NREG];
  logic [W-1:0] hi_d [NREG];

  logic [W-1:0] fix_src, fix_res;

  assign op     = op_e'(cmd_op_i);
  assign accept = cmd_valid_i & ~busy_q;

  always_comb begin
    add_a      = base_i[W-1:0];
    add_b      = index_i;
    add_signed = 1'b0;
    unique case (op)
      OP_STEP:   begin add_a = lo_q[SEL_PC]; add_b = W'(1); end
      OP_BRANCH: begin add_a = lo_q[SEL_PC]; add_b = offset_i; add_signed = 1'b1; end
      default: ;
    endcase
  end

  lo_byte_adder #(.W(W)) u_lo_add (
    .a_i      (add_a),
    .b_i      (add_b),
    .signed_i (add_signed),
    .sum_o    (add_sum),
    .fix_o    (add_fix)
  );

  assign fix_src = fix_ea_q ? hi_q[SEL_EA] : hi_q[SEL_PC];

  hi_byte_stepper #(.W(W)) u_hi_step (
    .hi_i  (fix_src),
    .dec_i (fix_dec_q),
    .hi_o  (fix_res)
  );

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      lo_we[r] = 1'b0;
      hi_we[r] = 1'b0;
      lo_d[r]  = add_sum;
      hi_d[r]  = fix_res;
    end
    if (busy_q) begin
      hi_we[fix_ea_q ? SEL_EA : SEL_PC] = 1'b1;
    end else if (accept) begin
      unique case (op)
        OP_STEP, OP_BRANCH: lo_we[SEL_PC] = 1'b1;
        OP_JUMP: begin
          lo_we[SEL_PC] = 1'b1;
          hi_we[SEL_PC] = 1'b1;
          lo_d[SEL_PC]  = base_i[W-1:0];
          hi_d[SEL_PC]  = base_i[2*W-1:W];
        end
        OP_ZPX: begin
          lo_we[SEL_EA] = 1'b1;
          hi_we[SEL_EA] = 1'b1;
          hi_d[SEL_EA]  = '0;
        end
        OP_INDY: begin
          lo_we[SEL_EA] = 1'b1;
          hi_we[SEL_EA] = 1'b1;
          hi_d[SEL_EA]  = base_i[2*W-1:W];
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [2*W-1:0] RV = (g == SEL_PC) ? RESET_VEC : '0;
    byte_pair_reg #(.W(W), .RST_VAL(RV)) u_pair (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lo_we_i (lo_we[g]),
      .lo_d_i  (lo_d[g]),
      .hi_we_i (hi_we[g]),
      .hi_d_i  (hi_d[g]),
      .lo_o    (lo_q[g]),
      .hi_o    (hi_q[g])
    );
  end

  // correction pending: only step, branch and base-indexed can carry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      fix_dec_q <= 1'b0;
      fix_ea_q  <= 1'b0;
    end else if (busy_q) begin
      busy_q <= 1'b0;
    end else if (accept && add_fix != FIX_NONE &&
                 (op == OP_STEP || op == OP_BRANCH || op == OP_INDY)) begin
      busy_q    <= 1'b1;
      fix_dec_q <= (add_fix == FIX_DEC);
      fix_ea_q  <= (op == OP_INDY);
    end
  end

  assign pc_o   = {hi_q[SEL_PC], lo_q[SEL_PC]};
  assign ea_o   = {hi_q[SEL_EA], lo_q[SEL_EA]};
  assign busy_o = busy_q;
endmodule

// File: rtl/pc_split_chk.sv
module pc_split_chk #(
  parameter int W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cmd_valid_i,
  input logic [2:0]     cmd_op_i,
  input logic [2*W-1:0] base_i,
  input logic [W-1:0]   offset_i,
  input logic [W-1:0]   index_i,
  input logic [2*W-1:0] pc_o,
  input logic [2*W-1:0] ea_o,
  input logic           busy_o
);
  logic take, is_idle;
  assign take    = cmd_valid_i && !busy_o;
  assign is_idle = !cmd_valid_i || cmd_op_i == 3'd0 || cmd_op_i > 3'd5;

  AST_STEP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && cmd_op_i == 3'd1 |=> pc_o[W-1:0] == W'($past(pc_o[W-1:0]) + 1'b1)); // R2
  AST_ONE_EXTRA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o); // R3
  AST_JUMP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && cmd_op_i == 3'd3 |=> !busy_o && pc_o == $past(base_i)); // R5
  AST_ZPX_PAGE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && cmd_op_i == 3'd4 |=> !busy_o && ea_o[2*W-1:W] == '0); // R6
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(pc_o[W-1:0]) && $stable(ea_o[W-1:0])); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && is_idle |=> $stable(pc_o) && $stable(ea_o)); // R9
endmodule

bind pc_split_unit pc_split_chk #(.W(W)) u_chk (.*);

// File: tb/pc_split_unit_bench.sv
`timescale 1ns/1ps
module pc_split_unit_bench;
  localparam int W = 8;
  localparam logic [15:0] RV = 16'h01FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] base = '0;
  logic [7:0]  offset = '0;
  logic [7:0]  index = '0;
  logic [15:0] pc, ea;
  logic        busy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pc_split_unit #(.W(W), .RESET_VEC(RV)) u_pc_split_unit (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .base_i(base), .offset_i(offset), .index_i(index),
    .pc_o(pc), .ea_o(ea), .busy_o(busy)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] start;
    logic [15:0] base;
    logic [7:0]  arg;
    logic [15:0] exp;
    logic [1:0]  extra;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 16'h1234, 16'h0000, 8'h00, 16'h1235, 2'd0},  // R2
    '{3'd1, 16'h12FF, 16'h0000, 8'h00, 16'h1300, 2'd1},  // R3
    '{3'd1, 16'hFFFF, 16'h0000, 8'h00, 16'h0000, 2'd1},  // R3
    '{3'd2, 16'h1210, 16'h0000, 8'h05, 16'h1215, 2'd0},  // R4
    '{3'd2, 16'h12F0, 16'h0000, 8'h20, 16'h1310, 2'd1},  // R4
    '{3'd2, 16'h1205, 16'h0000, 8'hF0, 16'h11F5, 2'd1},  // R4
    '{3'd2, 16'h1220, 16'h0000, 8'hF0, 16'h1210, 2'd0},  // R4
    '{3'd2, 16'h0000, 16'h0000, 8'hFF, 16'hFFFF, 2'd1},  // R4
    '{3'd2, 16'h127F, 16'h0000, 8'h80, 16'h11FF, 2'd1},  // R4
    '{3'd2, 16'h1200, 16'h0000, 8'h7F, 16'h127F, 2'd0},  // R4
    '{3'd3, 16'h12FF, 16'hABCD, 8'h00, 16'hABCD, 2'd0},  // R5
    '{3'd4, 16'h0000, 16'h12F0, 8'h20, 16'h0010, 2'd0},  // R6
    '{3'd4, 16'h0000, 16'h00FF, 8'h01, 16'h0000, 2'd0},  // R6
    '{3'd5, 16'h0000, 16'h2080, 8'h10, 16'h2090, 2'd0},  // R7
    '{3'd5, 16'h0000, 16'h20F0, 8'h10, 16'h2100, 2'd1},  // R7
    '{3'd5, 16'h0000, 16'hFFFF, 8'h01, 16'h0000, 2'd1}   // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] b, input logic [7:0] arg);
    cmd_valid = 1'b1; cmd_op = op; base = b; offset = arg; index = arg;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic drain(output int n);
    n = 0;
    for (int k = 0; k < 5 && busy; k++) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 pc", pc, RV);
    check("R1 ea", ea, 16'h0000);
    check("R1 busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pc after release", pc, RV);

    // first step from reset vector crosses a page
    issue(3'd1, 16'h0, 8'h0);
    check("R3 busy in fix cycle", busy, 1);
    check("R3 pc in fix cycle", pc, 16'h0100);
    drain(n);
    check("R3 pc after fix", pc, 16'h0200);

    for (int v = 0; v < NV; v++) begin
      issue(3'd3, VECS[v].start, 8'h0);
      issue(VECS[v].op, VECS[v].base, VECS[v].arg);
      drain(n);
      check($sformatf("R2-7 vec%0d extra", v), n, VECS[v].extra);
      if (VECS[v].op >= 3'd4)
        check($sformatf("R6/R7 vec%0d ea", v), ea, VECS[v].exp);
      else
        check($sformatf("R2/R4/R5 vec%0d pc", v), pc, VECS[v].exp);
    end

    // R8: commands during the fix cycle are dropped
    issue(3'd3, 16'h12FF, 8'h0);
    issue(3'd5, 16'h3000, 8'h00);
    cmd_valid = 1'b1; cmd_op = 3'd1;
    issue(3'd1, 16'h0, 8'h0);           // step: crosses, then fix cycle
    check("R8 busy", busy, 1);
    issue(3'd3, 16'h5555, 8'h0);        // jump during fix
    check("R8 pc after dropped jump", pc, 16'h1300);
    check("R8 busy cleared", busy, 0);
    issue(3'd1, 16'h0, 8'h0);
    issue(3'd1, 16'h0, 8'hFF);          // pc 1301 -> 1302 fine
    issue(3'd3, 16'h13FF, 8'h0);
    issue(3'd1, 16'h0, 8'h0);
    issue(3'd4, 16'h0077, 8'h01);       // zpx during fix
    check("R8 ea after dropped zpx", ea, 16'h3000);
    check("R8 pc", pc, 16'h1400);

    // R9: idle codes and no valid hold state
    issue(3'd6, 16'hBEEF, 8'h11);
    issue(3'd7, 16'hBEEF, 8'h11);
    issue(3'd0, 16'hBEEF, 8'h11);
    check("R9 pc idle", pc, 16'h1400);
    check("R9 ea idle", ea, 16'h3000);
    base = 16'hCAFE; cmd_op = 3'd3;
    @(negedge clk);
    check("R9 pc no valid", pc, 16'h1400);

    // R10: stacked crossings
    issue(3'd3, 16'h12FF, 8'h0);
    issue(3'd1, 16'h0, 8'h0);
    drain(n);
    begin
      int m;
      issue(3'd5, 16'h20F0, 8'h10);
      drain(m);
      check("R10 total extra", n + m, 2);
    end
    check("R10 pc", pc, 16'h1300);
    check("R10 ea", ea, 16'h2100);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule